// File: doc/BRIEF.md
# Multi-Source Interrupt Level Requester

This block gathers interrupt conditions from two peripherals and turns them into one prioritized request toward the host CPU. An Ethernet controller contributes two sources: a completion event, signalled by a rising edge on its active-low interrupt pin, and a bus-error termination, signalled by a single-cycle strobe from separate bus-error logic. A SCSI processor contributes one level-sensitive source, which is active while its active-low request line is held low. The two asynchronous pins pass through a two-flop synchronizer before they are examined.

Each source has its own control register. The register holds an enable bit and a 3-bit request level. Edge and strobe events set a sticky status bit, and software clears that bit by writing 1 to it. The level source is never latched. The block drives a registered 3-bit priority level together with a small ID that names the winning source. Software reaches the control and status bits through a simple read/write register port.

Top module: `irq_requester`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `ipl`, `irq_id` and `reg_rdata` are 0. Every control register resets to 0 (disabled, level 0) and every status bit resets to 0.
- R2: Register addresses are 0 = Ethernet completion, 1 = Ethernet bus-error, 2 = SCSI, and address 3 reads as 0. In each register, bits [2:0] hold the level, bit 3 the enable and bit 4 the status. A read strobe at clock edge n places that register on `reg_rdata` at edge n. `reg_rdata` holds its value until the next read.
- R3: A rising edge on `eth_int_n` that is sampled at edge k sets status bit 4 of address 0 at edge k+2. If that source is enabled, `ipl` carries its level from edge k+3.
- R4: `eth_buserr` high at edge k sets status bit 4 of address 1 at edge k. If that source is enabled, `ipl` carries its level from edge k+1.
- R5: `scsi_irq_n` held low from edge k onward makes the SCSI source active from edge k+1, and `ipl` reflects it from edge k+2. The source is not latched. Its status bit 4 reads the live synchronized state, and writes to that bit are ignored.
- R6: Writing 1 to bit 4 of address 0 or 1 clears that status bit. Writing 0 to bit 4 leaves it unchanged. If a new event arrives in the same cycle as the clear, the event wins.
- R7: Clearing a source's enable bit removes its request from `ipl` one clock later, and its latched status bit is kept.
- R8: A source programmed to level 0 never raises `ipl`, even when it is enabled and pending.
- R9: `ipl` is the highest level among the enabled, pending sources. `irq_id` is the winner's address plus 1. When levels are equal, the lower address wins.
- R10: `irq_id` is 0 exactly when `ipl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eth_int_n | input | 1 | Ethernet controller interrupt pin, active low, asynchronous |
| eth_buserr | input | 1 | Ethernet bus-error strobe, synchronous single cycle |
| scsi_irq_n | input | 1 | SCSI processor request, active low, asynchronous |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ipl | output | 3 | Interrupt priority level toward the CPU, 0 means none |
| irq_id | output | 2 | Winning source, 0 means none |

## Verification
Each result arrives with its own latency. A completion edge reaches `ipl` three edges after it is sampled. A SCSI low level reaches `ipl` after two edges, and a bus-error strobe after one. A control write or an enable change takes effect one edge later, and read data appears at the edge of the read strobe. The reference model in the bench keeps a short history of the sampled pin values and reads from it at exactly these depths. It settles every output at the clock edge and compares it at the following falling edge, so each expected value lines up with the cycle in which the hardware is due to change. The stimulus goes through completion, strobe and level events, equal-level ties, masking through level 0, enable removal, and a clear that collides with a new event.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 3;
  localparam int EN_BIT = 3;
  localparam int ST_BIT = 4;

  typedef struct packed {
    logic             en;
    logic [LVL_W-1:0] lvl;
  } ctrl_t;

  typedef enum logic [1:0] {
    SRC_EDGE   = 2'd0,
    SRC_STROBE = 2'd1,
    SRC_LEVEL  = 2'd2
  } kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_src.sv
module irq_src
  import irq_pkg::*;
#(
  parameter kind_e KIND = SRC_EDGE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic             wr_sel,
  input  logic [4:0]       wdata,
  output ctrl_t            ctrl_o,
  output logic             pend_o,
  output logic             set_o,
  output logic [LVL_W-1:0] req_lvl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_sel) ctrl_q <= ctrl_t'(wdata[EN_BIT:0]);
  end

  generate
    if (KIND == SRC_LEVEL) begin : g_level
      logic pin_s;
      irq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(pin), .q(pin_s));
      assign pend_o = ~pin_s;
      assign set_o  = 1'b0;
    end else begin : g_latched
      logic hit;
      logic stat_q;
      if (KIND == SRC_EDGE) begin : g_edge
        logic pin_s, pin_d;
        irq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
          .clk(clk), .rst(rst), .d(pin), .q(pin_s));
        always_ff @(posedge clk) begin
          if (rst) pin_d <= 1'b1;
          else     pin_d <= pin_s;
        end
        assign hit = pin_s & ~pin_d;
      end else begin : g_strobe
        assign hit = pin;
      end
      always_ff @(posedge clk) begin
        if (rst)                        stat_q <= 1'b0;
        else if (hit)                   stat_q <= 1'b1;
        else if (wr_sel && wdata[ST_BIT]) stat_q <= 1'b0;
      end
      assign pend_o = stat_q;
      assign set_o  = hit;
    end
  endgenerate

  assign ctrl_o    = ctrl_q;
  assign req_lvl_o = (pend_o && ctrl_q.en) ? ctrl_q.lvl : '0;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N     = 3,
  parameter int LVL_W = 3,
  localparam int ID_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req [N],
  output logic [LVL_W-1:0] ipl,
  output logic [ID_W-1:0]  id
);
  logic [LVL_W-1:0] best;
  logic [ID_W-1:0]  best_id;

  always_comb begin
    best    = '0;
    best_id = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] > best) begin
        best    = req[i];
        best_id = ID_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl <= '0;
      id  <= '0;
    end else begin
      ipl <= best;
      id  <= best_id;
    end
  end
endmodule

// File: rtl/irq_requester.sv
module irq_requester
  import irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int NSRC  = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eth_int_n,
  input  logic              eth_buserr,
  input  logic              scsi_irq_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LVL_W-1:0]  ipl,
  output logic [ID_W-1:0]   irq_id
);
  localparam kind_e KINDS [NSRC] = '{SRC_EDGE, SRC_STROBE, SRC_LEVEL};

  logic [NSRC-1:0]  src_pins;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  set_evt;
  logic [NSRC-1:0]  en;
  ctrl_t            ctrl [NSRC];
  logic [LVL_W-1:0] req  [NSRC];
  logic             unused_wdata;

  assign src_pins     = {scsi_irq_n, eth_buserr, eth_int_n};
  assign unused_wdata = ^reg_wdata[DATA_W-1:ST_BIT+1];

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      irq_src #(.KIND(KINDS[g])) u_src (
        .clk      (clk),
        .rst      (rst),
        .pin      (src_pins[g]),
        .wr_sel   (reg_wr && (reg_addr == ADDR_W'(g))),
        .wdata    (reg_wdata[ST_BIT:0]),
        .ctrl_o   (ctrl[g]),
        .pend_o   (pend[g]),
        .set_o    (set_evt[g]),
        .req_lvl_o(req[g])
      );
      assign en[g] = ctrl[g].en;
    end
  endgenerate

  irq_arb #(.N(NSRC), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .req(req), .ipl(ipl), .id(irq_id));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr == ADDR_W'(i))
          reg_rdata[ST_BIT:0] <= {pend[i], ctrl[i]};
      end
    end
  end
endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] ipl,
  input logic [1:0] irq_id,
  input logic       eth_buserr,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [2:0] pend,
  input logic [2:0] set_evt,
  input logic [2:0] en
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (ipl == 3'd0 && irq_id == 2'd0));

  // R10
  id_match_chk: assert property (@(posedge clk) disable iff (rst)
    (ipl == 3'd0) == (irq_id == 2'd0));

  // R4
  buserr_latch_chk: assert property (@(posedge clk) disable iff (rst)
    eth_buserr |=> pend[1]);

  // R6
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[4] && !set_evt[0]) |=> !pend[0]);

  // R6
  clear_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[4] && !set_evt[1]) |=> !pend[1]);

  // R7
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en == 3'b000) |=> (ipl == 3'd0));

  // R7
  keep_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[4])) |=> pend[0]);
endmodule

bind irq_requester irq_requester_chk u_chk (
  .clk(clk), .rst(rst), .ipl(ipl), .irq_id(irq_id), .eth_buserr(eth_buserr),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pend(pend), .set_evt(set_evt), .en(en));

// File: tb/test_irq_requester.sv
module test_irq_requester;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eth_int_n = 1'b1, eth_buserr = 1'b0, scsi_irq_n = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] ipl;
  logic [1:0] irq_id;

  irq_requester i_irq_requester (
    .clk(clk), .rst(rst), .eth_int_n(eth_int_n), .eth_buserr(eth_buserr),
    .scsi_irq_n(scsi_irq_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ipl(ipl), .irq_id(irq_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit   qe[$], qs[$];
  bit   m_st[3];
  bit   m_en[3];
  int   m_lv[3];
  int   e_ipl, e_id, e_rd;
  int   compared = 0, mismatched = 0, cyc = 0;
  bit   started = 0;
  string phase = "R1";

  always @(posedge clk) begin
    bit pnd[3];
    int best, bid, a;
    bit s0, clr;
    started = 1;
    if (rst) begin
      qe = '{1, 1, 1, 1}; qs = '{1, 1, 1, 1};
      for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_en[i] = 0; m_lv[i] = 0; end
      e_ipl = 0; e_id = 0; e_rd = 0;
    end else begin
      a = int'(reg_addr);
      pnd[0] = m_st[0]; pnd[1] = m_st[1]; pnd[2] = !qs[1];
      best = 0; bid = 0;
      for (int i = 0; i < 3; i++)
        if (pnd[i] && m_en[i] && m_lv[i] > best) begin best = m_lv[i]; bid = i + 1; end
      e_ipl = best; e_id = bid;
      if (reg_rd) e_rd = (a < 3) ? (int'(pnd[a]) * 16 + int'(m_en[a]) * 8 + m_lv[a]) : 0;
      s0  = qe[1] && !qe[2];
      clr = reg_wr && reg_wdata[4];
      m_st[0] = s0 || (m_st[0] && !(clr && a == 0));
      m_st[1] = eth_buserr || (m_st[1] && !(clr && a == 1));
      if (reg_wr && a < 3) begin m_en[a] = reg_wdata[3]; m_lv[a] = int'(reg_wdata[2:0]); end
      qe.push_front(eth_int_n); void'(qe.pop_back());
      qs.push_front(scsi_irq_n); void'(qs.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (int'(ipl) !== e_ipl || int'(irq_id) !== e_id || int'(reg_rdata) !== e_rd) begin
        mismatched++;
        $display("FAIL %s cycle %0d: ipl/id/rdata actual %0d/%0d/%0h expected %0d/%0d/%0h",
                 phase, cyc, ipl, irq_id, reg_rdata, e_ipl, e_id, e_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired, actual cycle %0d expected below 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  initial begin
    phase = "R1"; idle(4); rst = 0; idle(2);
    // R2: program and read back all registers
    phase = "R2";
    wr(0, 8'h0B); wr(1, 8'h0D); wr(2, 8'h0A);
    rd(0); rd(1); rd(2); rd(3); idle(2);
    // R3: completion edge on eth_int_n
    phase = "R3";
    @(negedge clk) eth_int_n = 0; idle(3);
    @(negedge clk) eth_int_n = 1; idle(5); rd(0);
    // R6: write-1 clear, write-0 keep
    phase = "R6";
    wr(0, 8'h0B); idle(2); rd(0); wr(0, 8'h1B); idle(2); rd(0);
    // R4: bus-error strobe
    phase = "R4";
    @(negedge clk) eth_buserr = 1; @(negedge clk) eth_buserr = 0; idle(3); rd(1);
    // R9: higher level wins over completion
    phase = "R9";
    @(negedge clk) eth_int_n = 0; idle(2); @(negedge clk) eth_int_n = 1; idle(5);
    // R5: SCSI level, live status, write to status ignored
    phase = "R5";
    wr(1, 8'h1D); idle(2);
    @(negedge clk) scsi_irq_n = 0; idle(4); rd(2); wr(2, 8'h1A); idle(2); rd(2);
    @(negedge clk) scsi_irq_n = 1; idle(4); rd(2);
    // R9: tie between completion (addr 0) and SCSI (addr 2), both level 3
    phase = "R9";
    wr(2, 8'h0B); @(negedge clk) scsi_irq_n = 0; idle(4); rd(0);
    // R7: disable completion, status kept, SCSI takes over
    phase = "R7";
    wr(0, 8'h03); idle(3); rd(0);
    wr(2, 8'h03); idle(3);
    @(negedge clk) scsi_irq_n = 1; idle(3);
    // R8: level 0 masks even if enabled and pending
    phase = "R8";
    wr(0, 8'h08); idle(3); rd(0);
    @(negedge clk) eth_buserr = 1; @(negedge clk) eth_buserr = 0;
    wr(1, 8'h08); idle(3); rd(1);
    // R6: clear colliding with new strobe: strobe wins
    phase = "R6";
    wr(1, 8'h0D); idle(2);
    @(negedge clk) begin reg_wr = 1; reg_addr = 1; reg_wdata = 8'h1D; eth_buserr = 1; end
    @(negedge clk) begin reg_wr = 0; reg_wdata = 0; eth_buserr = 0; end
    idle(2); rd(1);
    // R10: clear everything, request vanishes with id 0
    phase = "R10";
    wr(0, 8'h10); wr(1, 8'h10); idle(3);
    // R1: reset in the middle of activity
    phase = "R1";
    @(negedge clk) eth_buserr = 1; wr(1, 8'h0F); @(negedge clk) eth_buserr = 0; idle(2);
    @(negedge clk) rst = 1; idle(3); @(negedge clk) rst = 0; idle(2); rd(1); idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule